// File: doc/BRIEF.md
# Decode-Stage Data Hazard Interlock

This block is the interlock for the decode stage of a five-stage in-order pipeline that has no forwarding paths. Source registers are read in the second stage and results are written back in the fifth. An instruction up to three slots behind the one producing its operand would therefore read a stale register value. The block compares each source register number of the decoding instruction against the destination register number held in the execute, memory and writeback stages. Only stages whose register write-enable is set take part in the comparison.

When any live comparison matches, the block stalls the front of the pipeline. It drops the program-counter write enable so the fetching instruction waits. It drops the fetch/decode register enable so the decoding instruction waits. It raises the bubble select so the surrounding pipeline loads a no-op into the decode/execute register. Register zero is hard-wired and never causes a stall. The block is purely combinational: its outputs follow the current stage contents in the same cycle. Repeated evaluation, cycle after cycle, produces the multi-cycle stall. This repetition ends when the producer retires from writeback.

Top module: `hazardStallUnit`

## Requirements
- R1: Source A (`srcRegs[4:0]`) causes a stall when it is non-zero and equals the destination field of a stage whose write-enable is set. Field layout: stage 0 is execute at `dstRegs[4:0]` with `dstWe[0]`, stage 1 is memory at `dstRegs[9:5]` with `dstWe[1]`, and stage 2 is writeback at `dstRegs[14:10]` with `dstWe[2]`.
- R2: Source B (`srcRegs[9:5]`) is compared in the same way, and the stall is the OR of the source A and source B results.
- R3: A source register number of zero never causes a stall, even when a write-enabled stage also names register zero.
- R4: A stage whose write-enable is low never causes a stall, whatever its destination field holds.
- R5: With no live match, `pcWrEn` = 1, `fetchDecEn` = 1 and `bubbleSel` = 0.
- R6: During a stall, `pcWrEn` and `fetchDecEn` are both 0, so the PC and the fetch/decode register hold.
- R7: `bubbleSel` is 1 exactly in the cycles where a stall is raised, so a no-op enters execute.
- R8: In a pipeline that advances when there is no stall and inserts a bubble when there is one, a consumer directly behind its producer stalls for exactly 3 cycles. A consumer two slots behind stalls for 2 cycles, three slots behind for 1 cycle, and four or more slots behind for none.
- R9: The outputs hold no state and depend only on the current input values within the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| srcRegs | input | 10 | Decode-stage source register numbers: source A in [4:0], source B in [9:5] |
| dstRegs | input | 15 | Destination register numbers of execute [4:0], memory [9:5] and writeback [14:10] |
| dstWe | input | 3 | Register write-enables of execute [0], memory [1] and writeback [2] |
| pcWrEn | output | 1 | Program counter update enable; 0 while stalled |
| fetchDecEn | output | 1 | Fetch/decode pipeline register load enable; 0 while stalled |
| bubbleSel | output | 1 | Selects a no-op into the decode/execute register; 1 while stalled |

## Verification
The assertions assume that a stage carrying a bubble, store or branch presents its write-enable low. They also assume that every input is a known value whenever it is examined. The bench keeps to these assumptions with its own behavioural pipeline. That pipeline clears write-enables on reset, loads write-enable 0 for each injected bubble, and drives all fields with defined values at every negative clock edge. Instruction programs set the producer-to-consumer distance from one to four slots and switch write-enable and register zero on and off. The stall lengths the block induces are measured against those distances.

// File: rtl/hzdPkg.sv
package hzdPkg;

  // Strobes from the interlock control to the front-end enables
  typedef struct packed {
    logic holdPc;
    logic holdFetch;
    logic injectBubble;
  } stallStrobes_t;

endpackage

// File: rtl/hzdCompare.sv
module hzdCompare #(
  parameter int REG_BITS   = 5,
  parameter int NUM_STAGES = 3,
  parameter int NUM_SRC    = 2,
  localparam int NUM_HITS  = NUM_SRC * NUM_STAGES
) (
  input  logic [NUM_SRC*REG_BITS-1:0]    srcRegs,
  input  logic [NUM_STAGES*REG_BITS-1:0] dstRegs,
  input  logic [NUM_STAGES-1:0]          dstWe,
  output logic [NUM_HITS-1:0]            hitVec
);

  for (genvar s = 0; s < NUM_SRC; s++) begin : gSrc
    logic [REG_BITS-1:0] srcField;
    logic                srcLive;
    assign srcField = srcRegs[s*REG_BITS +: REG_BITS];
    assign srcLive  = (srcField != '0);
    for (genvar g = 0; g < NUM_STAGES; g++) begin : gStage
      logic [REG_BITS-1:0] dstField;
      assign dstField = dstRegs[g*REG_BITS +: REG_BITS];
      assign hitVec[s*NUM_STAGES + g] = srcLive && dstWe[g] && (srcField == dstField);
    end
  end

  always_comb begin
    for (int s = 0; s < NUM_SRC; s++) begin
      for (int g = 0; g < NUM_STAGES; g++) begin
        // R4
        no_dead_stage_hit_chk: assert (dstWe[g] || !hitVec[s*NUM_STAGES + g])
          else $error("hit from a stage with write-enable low");
        // R3
        no_zero_reg_hit_chk: assert ((srcRegs[s*REG_BITS +: REG_BITS] != '0) || !hitVec[s*NUM_STAGES + g])
          else $error("hit on register zero");
      end
    end
  end

endmodule

// File: rtl/hzdControl.sv
module hzdControl
  import hzdPkg::*;
#(
  parameter int NUM_HITS = 6
) (
  input  logic [NUM_HITS-1:0] hitVec,
  output stallStrobes_t       strobes
);

  logic stallReq;

  assign stallReq = |hitVec;

  always_comb begin
    strobes              = '0;
    strobes.holdPc       = stallReq;
    strobes.holdFetch    = stallReq;
    strobes.injectBubble = stallReq;
  end

endmodule

// File: rtl/hazardStallUnit.sv
module hazardStallUnit
  import hzdPkg::*;
#(
  parameter int REG_BITS   = 5,
  parameter int NUM_STAGES = 3,
  parameter int NUM_SRC    = 2,
  localparam int NUM_HITS  = NUM_SRC * NUM_STAGES
) (
  input  logic [NUM_SRC*REG_BITS-1:0]    srcRegs,
  input  logic [NUM_STAGES*REG_BITS-1:0] dstRegs,
  input  logic [NUM_STAGES-1:0]          dstWe,
  output logic                           pcWrEn,
  output logic                           fetchDecEn,
  output logic                           bubbleSel
);

  logic [NUM_HITS-1:0] hitVec;
  stallStrobes_t       strobes;

  hzdCompare #(
    .REG_BITS  (REG_BITS),
    .NUM_STAGES(NUM_STAGES),
    .NUM_SRC   (NUM_SRC)
  ) uCompare (
    .srcRegs(srcRegs),
    .dstRegs(dstRegs),
    .dstWe  (dstWe),
    .hitVec (hitVec)
  );

  hzdControl #(
    .NUM_HITS(NUM_HITS)
  ) uControl (
    .hitVec (hitVec),
    .strobes(strobes)
  );

  assign pcWrEn     = !strobes.holdPc;
  assign fetchDecEn = !strobes.holdFetch;
  assign bubbleSel  = strobes.injectBubble;

  always_comb begin
    // R1 R2
    stall_on_hit_chk: assert (!(|hitVec) || (!pcWrEn && !fetchDecEn && bubbleSel))
      else $error("match seen but front end not stalled");
    // R5
    no_spurious_stall_chk: assert ((|hitVec) || (pcWrEn && fetchDecEn && !bubbleSel))
      else $error("stall raised without a match");
    // R6
    hold_pair_chk: assert (pcWrEn == fetchDecEn)
      else $error("PC and fetch/decode enables disagree");
    // R7
    bubble_iff_hold_chk: assert (bubbleSel == !pcWrEn)
      else $error("bubble select disagrees with hold");
    // R3
    zero_srcs_chk: assert ((srcRegs != '0) || !bubbleSel)
      else $error("stall with both sources zero");
  end

endmodule

// File: tb/tb_hazardStallUnit.sv
module tb_hazardStallUnit;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [9:0]  srcRegs;
  logic [14:0] dstRegs;
  logic [2:0]  dstWe;
  logic        pcWrEn, fetchDecEn, bubbleSel;

  int checks = 0;
  int errors = 0;

  typedef struct {
    int dst;
    bit we;
    int sa;
    int sb;
  } instr_t;

  instr_t prog[$];
  int     stallCnt[16];
  int     pDst[3];   // 0 execute, 1 memory, 2 writeback
  bit     pWe[3];

  hazardStallUnit dut (
    .srcRegs   (srcRegs),
    .dstRegs   (dstRegs),
    .dstWe     (dstWe),
    .pcWrEn    (pcWrEn),
    .fetchDecEn(fetchDecEn),
    .bubbleSel (bubbleSel)
  );

  task automatic check1(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic bit refStall(int a, int b);
    bit s = 0;
    for (int i = 0; i < 3; i++) begin
      if (pWe[i]) begin
        if (a != 0 && a == pDst[i]) s = 1;
        if (b != 0 && b == pDst[i]) s = 1;
      end
    end
    return s;
  endfunction

  task automatic drive(int a, int b);
    srcRegs = {5'(b), 5'(a)};
    dstRegs = {5'(pDst[2]), 5'(pDst[1]), 5'(pDst[0])};
    dstWe   = {pWe[2], pWe[1], pWe[0]};
  endtask

  task automatic checkOuts(string tag, bit expStall);
    check1({tag, " pcWrEn"},     32'(pcWrEn),     32'(!expStall));
    check1({tag, " fetchDecEn"}, 32'(fetchDecEn), 32'(!expStall));
    check1({tag, " bubbleSel"},  32'(bubbleSel),  32'(expStall));
  endtask

  task automatic clearPipe();
    for (int i = 0; i < 3; i++) begin
      pDst[i] = 0;
      pWe[i]  = 0;
    end
  endtask

  // Static vector: explicit stage contents and explicit expected stall
  task automatic vec(string tag, int a, int b, int d0, bit w0, int d1, bit w1,
                     int d2, bit w2, bit expStall);
    @(negedge clk);
    pDst[0] = d0; pWe[0] = w0;
    pDst[1] = d1; pWe[1] = w1;
    pDst[2] = d2; pWe[2] = w2;
    drive(a, b);
    #1;
    checkOuts(tag, expStall);
  endtask

  // Cycle-by-cycle pipeline model; checks outputs every clock
  task automatic runProgram(string tag);
    int     pc = 0;
    int     tail = 0;
    instr_t cur;
    bit     exp;
    clearPipe();
    for (int i = 0; i < 16; i++) stallCnt[i] = 0;
    while (tail < 4) begin
      @(negedge clk);
      if (pc < prog.size()) cur = prog[pc];
      else begin
        cur = '{dst: 0, we: 0, sa: 0, sb: 0};
        tail++;
      end
      drive(cur.sa, cur.sb);
      #1;
      exp = refStall(cur.sa, cur.sb);
      checkOuts({tag, " R9 per-cycle"}, exp);
      if (exp && pc < prog.size()) stallCnt[pc]++;
      @(posedge clk);
      pDst[2] = pDst[1]; pWe[2] = pWe[1];
      pDst[1] = pDst[0]; pWe[1] = pWe[0];
      if (exp) begin
        pDst[0] = 0; pWe[0] = 0;
      end else begin
        pDst[0] = cur.dst; pWe[0] = cur.we;
        if (pc < prog.size()) pc++;
      end
    end
  endtask

  function automatic instr_t mk(int dst, bit we, int sa, int sb);
    mk = '{dst: dst, we: we, sa: sa, sb: sb};
  endfunction

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    clearPipe();
    drive(0, 0);
    repeat (2) @(posedge clk);
    @(negedge clk);
    #1;
    checkOuts("R5 reset empty pipeline", 1'b0);

    // Static cases
    vec("R1 srcA vs execute",   3, 0, 3, 1, 0, 0, 0, 0, 1'b1);
    vec("R1 srcA vs memory",    7, 9, 1, 1, 7, 1, 2, 1, 1'b1);
    vec("R1 srcA vs writeback", 31, 4, 5, 1, 6, 1, 31, 1, 1'b1);
    vec("R2 srcB vs memory",    2, 12, 8, 1, 12, 1, 9, 1, 1'b1);
    vec("R2 srcB vs writeback", 0, 17, 0, 0, 0, 0, 17, 1, 1'b1);
    vec("R3 zero sources",      0, 0, 0, 1, 0, 1, 0, 1, 1'b0);
    vec("R3 srcA zero srcB ok", 0, 6, 0, 1, 4, 1, 5, 1, 1'b0);
    vec("R4 we low execute",    3, 3, 3, 0, 0, 0, 0, 0, 1'b0);
    vec("R4 all we low",        9, 10, 9, 0, 10, 0, 9, 0, 1'b0);
    vec("R5 no match",          1, 2, 3, 1, 4, 1, 5, 1, 1'b0);
    vec("R9 inputs change",     1, 2, 1, 1, 4, 1, 5, 1, 1'b1);
    vec("R9 inputs restore",    1, 2, 3, 1, 4, 1, 5, 1, 1'b0);

    // R8 back-to-back via source A
    prog = {mk(3, 1, 1, 2), mk(5, 1, 3, 4)};
    runProgram("R8 b2b srcA");
    check1("R8 b2b srcA stall count", 32'(stallCnt[1]), 32'd3);
    check1("R8 producer no stall", 32'(stallCnt[0]), 32'd0);

    // R2 back-to-back via source B
    prog = {mk(8, 1, 1, 2), mk(5, 1, 4, 8)};
    runProgram("R2 b2b srcB");
    check1("R2 b2b srcB stall count", 32'(stallCnt[1]), 32'd3);

    // R8 distance two, three, four
    prog = {mk(4, 1, 1, 2), mk(6, 1, 7, 9), mk(10, 1, 4, 1)};
    runProgram("R8 dist2");
    check1("R8 dist2 stall count", 32'(stallCnt[2]), 32'd2);
    prog = {mk(4, 1, 1, 2), mk(6, 1, 7, 9), mk(11, 1, 7, 8), mk(10, 1, 1, 4)};
    runProgram("R8 dist3");
    check1("R8 dist3 stall count", 32'(stallCnt[3]), 32'd1);
    prog = {mk(4, 1, 1, 2), mk(6, 1, 7, 9), mk(11, 1, 7, 8), mk(13, 1, 9, 9),
            mk(10, 1, 4, 4)};
    runProgram("R8 dist4");
    check1("R8 dist4 stall count", 32'(stallCnt[4]), 32'd0);

    // R5 independent stream never stalls
    prog = {mk(10, 1, 1, 2), mk(11, 1, 3, 4), mk(12, 1, 5, 6), mk(13, 1, 7, 8),
            mk(14, 1, 1, 9), mk(15, 1, 2, 3)};
    runProgram("R5 independent");
    begin
      int tot = 0;
      for (int i = 0; i < 6; i++) tot += stallCnt[i];
      check1("R5 independent total stalls", 32'(tot), 32'd0);
    end

    // R4 producer without register write (store-like)
    prog = {mk(3, 0, 1, 2), mk(5, 1, 3, 3)};
    runProgram("R4 no-write producer");
    check1("R4 no-write producer stalls", 32'(stallCnt[1]), 32'd0);

    // R3 producer writing register zero
    prog = {mk(0, 1, 1, 2), mk(5, 1, 0, 0)};
    runProgram("R3 r0 producer");
    check1("R3 r0 consumer stalls", 32'(stallCnt[1]), 32'd0);

    // R6 R7 chained dependencies: second consumer waits on first
    prog = {mk(3, 1, 1, 2), mk(4, 1, 3, 0), mk(6, 1, 4, 0)};
    runProgram("R6 R7 chain");
    check1("R7 chain first stalls", 32'(stallCnt[1]), 32'd3);
    check1("R6 chain second stalls", 32'(stallCnt[2]), 32'd3);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule